// File: doc/BRIEF.md
# Self-ID Receive Buffer Pool

This block owns three word-wide packet memories of different sizes (a receive memory, a transmit memory and a larger bridge memory) and groups them into a logical receive buffer and a logical transmit buffer. The grouping depends on two mode inputs, a memory-select bit and a direction bit, and on whether the block is in the self-identification phase that follows a serial-bus reset. When a chained buffer spans two memories, its pointers run from the top of the receive memory into the second memory without a gap.

When a bus reset completes, the block raises its receive-busy flag, empties the buffers and forms a large chained receive buffer that collects the incoming self-ID words from the link side. The host issues the receive command (code 03h), then reads the data port one word at a time while the data-request flag is high. The remove-busy command (code 04h) ends the phase. It drops the busy flag, empties the buffers and regroups the memories into their normal arrangement.

The incoming word stream is a valid-only interface. The link cannot be stalled, so the block applies no back-pressure. A word that arrives while the receive buffer is full is discarded and recorded in a sticky overflow flag.

Top module: `selfid_rx_pool`

## Requirements
- R1: After reset, rx_busy, data_req, overflow and rd_data are 0. The receive buffer is the receive memory alone (rx_cap_words = RX_WORDS) and the transmit buffer is the transmit memory alone (tx_cap_words = TX_WORDS).
- R2: A bus_reset_done pulse sets rx_busy to 1 and empties the buffers. If mode_sel=1 and mode_dir=1, the receive buffer becomes the receive plus bridge memories (RX_WORDS+BR_WORDS) and the transmit buffer keeps TX_WORDS. Otherwise the receive buffer becomes the receive plus transmit memories (RX_WORDS+TX_WORDS) and tx_cap_words is 0.
- R3: Each cycle with in_valid high appends in_data to the receive buffer if it holds fewer words than rx_cap_words. Otherwise the word is dropped and overflow goes to 1 and stays there until the buffers are next emptied.
- R4: A command with cmd_code 8'h03 arms the data port. data_req is 1 exactly when the port is armed and the receive buffer is not empty.
- R5: A cycle with rd_en high while data_req is 1 removes the oldest word, and rd_data shows it from the next cycle on. Words come out in arrival order, across the boundary between two chained memories and across pointer wrap-around.
- R6: A cycle with rd_en high while data_req is 0 (buffer empty, or port not armed) sets rd_data to 0 and removes nothing.
- R7: A command with cmd_code 8'h04 clears rx_busy, empties the buffers, clears overflow, disarms the port and applies the normal grouping. mode_sel=1 and mode_dir=1 gives receive RX_WORDS+BR_WORDS and transmit TX_WORDS. mode_sel=1 and mode_dir=0 gives receive RX_WORDS and transmit TX_WORDS+BR_WORDS. mode_sel=0 gives receive RX_WORDS and transmit TX_WORDS.
- R8: mode_sel and mode_dir are sampled only at a bus reset or a remove-busy command. Changing them at any other time leaves both capacities unchanged.
- R9: A command with any other cmd_code changes nothing. bus_reset_done takes precedence over a command in the same cycle.
- R10: A write and a read in the same cycle both take effect. The word count is unchanged and the written word is queued behind the remaining words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Memory-select mode bit |
| mode_dir | input | 1 | Direction mode bit |
| bus_reset_done | input | 1 | One-cycle pulse when a bus reset completes |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 8 | Host command code |
| in_valid | input | 1 | Incoming word valid (no back-pressure) |
| in_data | input | DW | Incoming word |
| rd_en | input | 1 | Host read of the data port |
| rd_data | output | DW | Word returned by the last host read |
| data_req | output | 1 | More words are ready for the host |
| rx_busy | output | 1 | Self-ID phase in progress |
| overflow | output | 1 | A word was dropped on a full buffer |
| rx_cap_words | output | CW | Current receive buffer capacity in words |
| tx_cap_words | output | TCW | Current transmit buffer capacity in words |

## Verification
The bench builds the block with RX_WORDS=4, TX_WORDS=4 and BR_WORDS=8 instead of the default 64/64/512. With these sizes, every grouping can be filled to its limit in a few dozen cycles. The overflow drop, the read across the boundary from the receive memory into the transmit or bridge memory, and pointer wrap-around in the single-memory buffer are all reached by short directed sequences. The capacity values for each grouping stay small enough to tell apart by eye.

// File: rtl/selfid_pool_pkg.sv
package selfid_pool_pkg;

  localparam logic [7:0] CMD_RECV    = 8'h03;
  localparam logic [7:0] CMD_RM_BUSY = 8'h04;

  // chain    : receive buffer spans two memories
  // second_br: second receive memory is the bridge memory (else transmit)
  // tx_br    : transmit buffer is transmit plus bridge memory
  // tx_lent  : transmit memory is lent to the receive buffer
  typedef struct packed {
    logic chain;
    logic second_br;
    logic tx_br;
    logic tx_lent;
  } grp_t;

  function automatic grp_t pick_group(input logic sel, input logic dir,
                                      input logic selfid);
    grp_t g;
    g.chain     = selfid | (sel & dir);
    g.second_br = sel & dir;
    g.tx_br     = ~selfid & sel & ~dir;
    g.tx_lent   = selfid & ~(sel & dir);
    return g;
  endfunction

endpackage

// File: rtl/sp_word_mem.sv
module sp_word_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sp_cmd_group.sv
module sp_cmd_group
  import selfid_pool_pkg::*;
#(
  parameter int RX_WORDS = 64,
  parameter int TX_WORDS = 64,
  parameter int BR_WORDS = 512,
  localparam int MAXW = RX_WORDS + ((BR_WORDS > TX_WORDS) ? BR_WORDS : TX_WORDS),
  localparam int CW   = $clog2(MAXW + 1),
  localparam int TCW  = $clog2(TX_WORDS + BR_WORDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sel,
  input  logic           mode_dir,
  input  logic           bus_reset_done,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_code,
  output logic           clr,
  output logic           armed,
  output logic           busy,
  output logic           second_br,
  output logic [CW-1:0]  rx_cap,
  output logic [TCW-1:0] tx_cap
);
  grp_t grp;
  logic rm_busy, recv;

  assign rm_busy = cmd_valid && (cmd_code == CMD_RM_BUSY);
  assign recv    = cmd_valid && (cmd_code == CMD_RECV);
  assign clr     = bus_reset_done || rm_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp   <= pick_group(1'b0, 1'b0, 1'b0);
      busy  <= 1'b0;
      armed <= 1'b0;
    end else if (bus_reset_done) begin
      grp   <= pick_group(mode_sel, mode_dir, 1'b1);
      busy  <= 1'b1;
      armed <= 1'b0;
    end else if (rm_busy) begin
      grp   <= pick_group(mode_sel, mode_dir, 1'b0);
      busy  <= 1'b0;
      armed <= 1'b0;
    end else if (recv) begin
      armed <= 1'b1;
    end
  end

  assign second_br = grp.second_br;

  always_comb begin
    rx_cap = CW'(RX_WORDS);
    if (grp.chain) rx_cap = grp.second_br ? CW'(RX_WORDS + BR_WORDS)
                                          : CW'(RX_WORDS + TX_WORDS);
    if (grp.tx_lent)    tx_cap = '0;
    else if (grp.tx_br) tx_cap = TCW'(TX_WORDS + BR_WORDS);
    else                tx_cap = TCW'(TX_WORDS);
  end

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_done |=> busy && !armed);
  assert_rm_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_busy && !bus_reset_done) |=> !busy && !armed);
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(rx_cap) && $stable(tx_cap));
  assert_other_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !recv && !rm_busy && !bus_reset_done) |=> $stable(busy) && $stable(armed));
endmodule

// File: rtl/sp_ring_ptr.sv
module sp_ring_ptr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] wr_ptr,
  output logic [CW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [CW-1:0] last;

  assign last    = cap - CW'(1);
  assign pop_ok  = pop_req && (count != '0);
  assign push_ok = push_req && (count < cap);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok)  wr_ptr <= (wr_ptr == last) ? '0 : wr_ptr + CW'(1);
      if (pop_ok)   rd_ptr <= (rd_ptr == last) ? '0 : rd_ptr + CW'(1);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
      if (push_req && !push_ok) overflow <= 1'b1;
    end
  end

  assert_count_in_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && count == cap && !clr) |=> overflow);
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0 && !overflow);
  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !clr) |=> $stable(count));
endmodule

// File: rtl/selfid_rx_pool.sv
module selfid_rx_pool #(
  parameter int DW       = 32,
  parameter int RX_WORDS = 64,
  parameter int TX_WORDS = 64,
  parameter int BR_WORDS = 512,
  localparam int MAXW = RX_WORDS + ((BR_WORDS > TX_WORDS) ? BR_WORDS : TX_WORDS),
  localparam int CW   = $clog2(MAXW + 1),
  localparam int TCW  = $clog2(TX_WORDS + BR_WORDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sel,
  input  logic           mode_dir,
  input  logic           bus_reset_done,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_code,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_data,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  output logic           data_req,
  output logic           rx_busy,
  output logic           overflow,
  output logic [CW-1:0]  rx_cap_words,
  output logic [TCW-1:0] tx_cap_words
);
  localparam int RAW = (RX_WORDS > 1) ? $clog2(RX_WORDS) : 1;
  localparam int TAW = (TX_WORDS > 1) ? $clog2(TX_WORDS) : 1;
  localparam int BAW = (BR_WORDS > 1) ? $clog2(BR_WORDS) : 1;

  logic          clr, armed, second_br, push_ok, pop_ok;
  logic [CW-1:0] wr_ptr, rd_ptr, count, w_off, r_off;
  logic          w_low, r_low;
  logic [DW-1:0] rx_q, tx_q, br_q, head;

  sp_cmd_group #(.RX_WORDS(RX_WORDS), .TX_WORDS(TX_WORDS), .BR_WORDS(BR_WORDS)) u_grp (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_dir(mode_dir),
    .bus_reset_done(bus_reset_done), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .clr(clr), .armed(armed), .busy(rx_busy), .second_br(second_br),
    .rx_cap(rx_cap_words), .tx_cap(tx_cap_words)
  );

  sp_ring_ptr #(.CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap(rx_cap_words),
    .push_req(in_valid), .pop_req(rd_en && armed),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .overflow(overflow)
  );

  // logical address below RX_WORDS lands in the receive memory,
  // the rest in the second memory of the chain
  assign w_low = wr_ptr < CW'(RX_WORDS);
  assign r_low = rd_ptr < CW'(RX_WORDS);
  assign w_off = wr_ptr - CW'(RX_WORDS);
  assign r_off = rd_ptr - CW'(RX_WORDS);

  sp_word_mem #(.DW(DW), .DEPTH(RX_WORDS)) u_rx_mem (
    .clk(clk), .we(push_ok && w_low), .waddr(RAW'(wr_ptr)), .wdata(in_data),
    .raddr(RAW'(rd_ptr)), .rdata(rx_q)
  );
  sp_word_mem #(.DW(DW), .DEPTH(TX_WORDS)) u_tx_mem (
    .clk(clk), .we(push_ok && !w_low && !second_br), .waddr(TAW'(w_off)),
    .wdata(in_data), .raddr(TAW'(r_off)), .rdata(tx_q)
  );
  sp_word_mem #(.DW(DW), .DEPTH(BR_WORDS)) u_br_mem (
    .clk(clk), .we(push_ok && !w_low && second_br), .waddr(BAW'(w_off)),
    .wdata(in_data), .raddr(BAW'(r_off)), .rdata(br_q)
  );

  assign head     = r_low ? rx_q : (second_br ? br_q : tx_q);
  assign data_req = armed && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= pop_ok ? head : '0;
  end

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_req) |=> rd_data == '0);
  assert_req_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_req);
endmodule

// File: tb/selfid_rx_pool_test.sv
module selfid_rx_pool_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, RXW = 4, TXW = 4, BRW = 8;
  localparam int CW  = $clog2(RXW + BRW + 1);
  localparam int TCW = $clog2(TXW + BRW + 1);

  logic clk = 0, rst_n = 0;
  logic mode_sel = 0, mode_dir = 0, bus_reset_done = 0, cmd_valid = 0;
  logic [7:0] cmd_code = 0;
  logic in_valid = 0, rd_en = 0;
  logic [DW-1:0] in_data = 0, rd_data;
  logic data_req, rx_busy, overflow;
  logic [CW-1:0] rx_cap_words;
  logic [TCW-1:0] tx_cap_words;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfid_rx_pool #(.DW(DW), .RX_WORDS(RXW), .TX_WORDS(TXW), .BR_WORDS(BRW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_dir(mode_dir),
    .bus_reset_done(bus_reset_done), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .in_valid(in_valid), .in_data(in_data), .rd_en(rd_en), .rd_data(rd_data),
    .data_req(data_req), .rx_busy(rx_busy), .overflow(overflow),
    .rx_cap_words(rx_cap_words), .tx_cap_words(tx_cap_words)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busreset(logic s, logic d);
    mode_sel = s; mode_dir = d; bus_reset_done = 1; tick(); bus_reset_done = 0;
  endtask

  task automatic cmd(logic [7:0] c);
    cmd_valid = 1; cmd_code = c; tick(); cmd_valid = 0;
  endtask

  task automatic push(logic [DW-1:0] w);
    in_valid = 1; in_data = w; tick(); in_valid = 0;
  endtask

  task automatic pop(output logic [DW-1:0] w);
    rd_en = 1; tick(); rd_en = 0; w = rd_data;
  endtask

  task automatic t_reset();
    check("R1 busy", rx_busy, 0);
    check("R1 data_req", data_req, 0);
    check("R1 overflow", overflow, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 rx_cap", rx_cap_words, RXW);
    check("R1 tx_cap", tx_cap_words, TXW);
  endtask

  task automatic t_selfid_bridge();
    logic [DW-1:0] w;
    busreset(1, 1);
    check("R2 busy", rx_busy, 1);
    check("R2 rx_cap bridge", rx_cap_words, RXW + BRW);
    check("R2 tx_cap bridge", tx_cap_words, TXW);
    for (int i = 0; i < RXW + BRW; i++) push(32'h100 + i);
    check("R3 no drop at cap", overflow, 0);
    push(32'hDEAD);
    check("R3 overflow", overflow, 1);
    check("R4 not armed", data_req, 0);
    pop(w);
    check("R6 unarmed read", w, 0);
    cmd(8'h03);
    check("R4 armed", data_req, 1);
    for (int i = 0; i < RXW + BRW; i++) begin
      check("R4 req while data", data_req, 1);
      pop(w);
      check("R5 order bridge", w, 32'h100 + i);
    end
    check("R4 req empty", data_req, 0);
    pop(w);
    check("R6 empty read", w, 0);
    check("R3 sticky overflow", overflow, 1);
  endtask

  task automatic t_hold_and_other();
    mode_sel = 0; mode_dir = 0; tick(); tick();
    check("R8 rx_cap held", rx_cap_words, RXW + BRW);
    check("R8 tx_cap held", tx_cap_words, TXW);
    cmd(8'h05);
    check("R9 busy kept", rx_busy, 1);
    check("R9 overflow kept", overflow, 1);
    check("R9 cap kept", rx_cap_words, RXW + BRW);
  endtask

  task automatic t_rm_busy_txbr();
    mode_sel = 1; mode_dir = 0; cmd(8'h04);
    check("R7 busy clear", rx_busy, 0);
    check("R7 overflow clear", overflow, 0);
    check("R7 data_req", data_req, 0);
    check("R7 rx_cap txbr", rx_cap_words, RXW);
    check("R7 tx_cap txbr", tx_cap_words, TXW + BRW);
  endtask

  task automatic t_selfid_tx();
    logic [DW-1:0] w;
    busreset(0, 1);
    check("R2 rx_cap tx chain", rx_cap_words, RXW + TXW);
    check("R2 tx_cap lent", tx_cap_words, 0);
    for (int i = 0; i < RXW + TXW + 1; i++) push(32'h200 + i);
    check("R3 overflow tx chain", overflow, 1);
    cmd(8'h03);
    for (int i = 0; i < RXW + TXW; i++) begin
      pop(w);
      check("R5 order tx chain", w, 32'h200 + i);
    end
    check("R4 drained", data_req, 0);
  endtask

  task automatic t_normal_modes();
    mode_sel = 1; mode_dir = 1; cmd(8'h04);
    check("R7 rx_cap sel dir", rx_cap_words, RXW + BRW);
    check("R7 tx_cap sel dir", tx_cap_words, TXW);
    mode_sel = 0; mode_dir = 1; cmd(8'h04);
    check("R7 rx_cap plain", rx_cap_words, RXW);
    check("R7 tx_cap plain", tx_cap_words, TXW);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] w;
    cmd(8'h03);
    for (int i = 0; i < 3; i++) push(32'h300 + i);
    pop(w); check("R5 wrap first", w, 32'h300);
    pop(w); check("R5 wrap second", w, 32'h301);
    for (int i = 3; i < 6; i++) push(32'h300 + i);
    check("R3 full no drop", overflow, 0);
    push(32'hBAD);
    check("R3 overflow wrap", overflow, 1);
    for (int i = 2; i < 6; i++) begin
      pop(w);
      check("R5 wrap order", w, 32'h300 + i);
    end
    check("R4 wrap empty", data_req, 0);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] w;
    cmd(8'h04);
    cmd(8'h03);
    push(32'hA1);
    in_valid = 1; in_data = 32'hB2; rd_en = 1; tick();
    in_valid = 0; rd_en = 0;
    check("R10 read during write", rd_data, 32'hA1);
    check("R10 still data", data_req, 1);
    pop(w);
    check("R10 queued word", w, 32'hB2);
    check("R10 empty after", data_req, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_selfid_bridge();
    t_hold_and_other();
    t_rm_busy_txbr();
    t_selfid_tx();
    t_normal_modes();
    t_wrap();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule